// File: doc/BRIEF.md
# SPI Register Bank Slave

This block is an SPI slave that gives an external host read and write access to a small bank of 32-bit registers. It runs in the system clock domain. The serial clock, chip select and data-in pins are each passed through a two-stage synchronizer, and the serial clock edges are detected after that synchronizer. The serial clock must therefore be many times slower than the system clock.

Every transaction begins with a command byte. Its top bit is the direction: 1 means read and 0 means write. Its low seven bits are the register address. Four data bytes follow, most significant byte first. Both sides use SPI mode 0: the clock idles low and data is captured on the rising edge.

The bank has three kinds of register:
- A set of 32-bit configuration registers. Each drives an output bus and gives a one-cycle write pulse.
- A one-bit test-mode enable at a fixed address, readable and writable.
- A set of read-only status words taken from input ports.

Top module: `spi_regbank`

## Requirements
- R1: After reset, all configuration registers and the test-mode bit are zero, `cfg_wr` is low and `spi_miso` is 0.
- R2: A command byte with bit 7 = 0 selects a write, and bits 6:0 give the address. The following 32 bits are taken most significant bit first. When the 32nd data bit is captured, a configuration register at address `0..NUM_CFG-1` takes the word, and its bit of `cfg_wr` pulses high for exactly one clock.
- R3: A command byte with bit 7 = 1 selects a read. Bit 31 of the addressed register is on `spi_miso` before the ninth rising serial clock edge. Each later rising edge advances the output by one bit, down to bit 0. During the command byte the output is don't-care.
- R4: Address `TEST_ADDR` (default 4) holds the test-mode bit. A write stores data bit 0 and drives it on `test_mode`. A read returns that bit in bit 0, with zeros in bits 31:1.
- R5: Addresses `STAT_BASE + k` (default 8 and 9) read status word k, which is `stat_in[32k+31:32k]`. Writes to these addresses change nothing.
- R6: Reads of any other address return zero. Writes to any other address change no register and give no `cfg_wr` pulse.
- R7: If chip select goes high before the 32nd data bit, the write is dropped. The next transaction starts again from a fresh command byte.
- R8: Read data is captured when the command byte completes. A change on `stat_in` during the data phase does not alter the bits being shifted out.
- R9: While chip select is inactive, `spi_miso` is driven 0, after the synchronizer delay.
- R10: Serial clock edges beyond the 40th in one chip-select period are ignored. Each transaction commits at most one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| stat_in | input | NUM_STAT*DW | Read-only status words |
| cfg_q | output | NUM_CFG*DW | Configuration register contents, register i in bits i*DW +: DW |
| cfg_wr | output | NUM_CFG | One-cycle write pulse per configuration register |
| test_mode | output | 1 | Test-mode enable bit |

## Verification
The bench uses the default parameters: four configuration registers, the test-mode bit at address 4, status words at addresses 8 and 9, and a two-flop synchronizer. With these values every address class can be reached within one 7-bit address. That covers a configuration word, the single-bit register, the live status inputs, the gaps at 5 to 7 and the top address 0x7F. The slow serial clock, four system clocks per half period, leaves the synchronizer latency visible. This lets the per-clock model check when writes commit, when the read snapshot is taken, and how long chip select takes to reach the idle output.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int DW        = 32,
  parameter int NUM_CFG   = 4,
  parameter int TEST_ADDR = 4,
  parameter int STAT_BASE = 8,
  parameter int NUM_STAT  = 2,
  parameter int SYNC      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sck,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic [NUM_STAT*DW-1:0] stat_in,
  output logic [NUM_CFG*DW-1:0]  cfg_q,
  output logic [NUM_CFG-1:0]     cfg_wr,
  output logic                   test_mode
);

  localparam int FRAME = 8 + DW;
  localparam int CW    = $clog2(FRAME + 1);

  logic [SYNC:0]   sck_p;
  logic [SYNC-1:0] cs_p;
  logic [SYNC-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC-1:0], spi_sck};
      cs_p   <= {cs_p[SYNC-2:0], spi_cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], spi_mosi};
    end
  end

  wire cs_s   = cs_p[SYNC-1];
  wire mosi_s = mosi_p[SYNC-1];
  wire rise   = sck_p[SYNC-1] & ~sck_p[SYNC] & ~cs_s;

  logic [CW-1:0]   cnt;
  logic [DW-2:0]   sh_in;
  logic [7:0]      cmd;
  logic [DW-1:0]   sh_out;
  logic [DW-1:0]   cfg_r [NUM_CFG];
  logic            test_r;
  logic [DW-1:0]   rd_val;

  wire [7:0]    cmd_nx  = {sh_in[6:0], mosi_s};
  wire [DW-1:0] word_nx = {sh_in, mosi_s};
  wire          step    = rise && (cnt != CW'(FRAME));
  wire          cmd_end = step && (cnt == CW'(7));
  wire          in_data = cnt >= CW'(8);
  wire          commit  = step && (cnt == CW'(FRAME - 1)) && !cmd[7];
  wire [6:0]    wr_addr = cmd[6:0];

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (cmd_nx[6:0] == 7'(i)) rd_val = cfg_r[i];
    if (cmd_nx[6:0] == 7'(TEST_ADDR)) rd_val = {{(DW-1){1'b0}}, test_r};
    for (int s = 0; s < NUM_STAT; s++)
      if (cmd_nx[6:0] == 7'(STAT_BASE + s)) rd_val = stat_in[s*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh_in  <= '0;
      cmd    <= '0;
      sh_out <= '0;
    end else begin
      if (cs_s) begin
        cnt <= '0;
      end else if (step) begin
        cnt   <= cnt + CW'(1);
        sh_in <= word_nx[DW-2:0];
        if (cmd_end) cmd <= cmd_nx;
      end
      if (cmd_end && cmd_nx[7])
        sh_out <= rd_val;
      else if (step && in_data)
        sh_out <= {sh_out[DW-2:0], 1'b0};
    end
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r[i]  <= '0;
        cfg_wr[i] <= 1'b0;
      end else begin
        cfg_wr[i] <= commit && (wr_addr == 7'(i));
        if (commit && (wr_addr == 7'(i))) cfg_r[i] <= word_nx;
      end
    end
    assign cfg_q[i*DW +: DW] = cfg_r[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      test_r <= 1'b0;
    else if (commit && (wr_addr == 7'(TEST_ADDR)))
      test_r <= word_nx[0];
  end

  assign test_mode = test_r;
  assign spi_miso  = ~cs_s & sh_out[DW-1];

endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int DW      = 32,
  parameter int NUM_CFG = 4,
  parameter int FRAME   = 40,
  parameter int CW      = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_cs_n,
  input logic                  spi_miso,
  input logic [NUM_CFG*DW-1:0] cfg_q,
  input logic [NUM_CFG-1:0]    cfg_wr,
  input logic                  test_mode,
  input logic                  commit,
  input logic [CW-1:0]         bit_cnt
);

  p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr));

  p_cfg_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> (cfg_wr != '0));

  p_wr_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr != '0) |-> $past(commit));

  p_test_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != $past(test_mode)) |-> $past(commit));

  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |=> (bit_cnt == '0));

  p_idle_miso_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);

  p_cnt_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FRAME));

endmodule

bind spi_regbank spi_regbank_chk #(
  .DW(DW), .NUM_CFG(NUM_CFG), .FRAME(FRAME), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .cfg_q(cfg_q), .cfg_wr(cfg_wr), .test_mode(test_mode),
  .commit(commit), .bit_cnt(cnt)
);

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int CLK_T = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [63:0]  stat = 64'h89AB_CDEF_0246_8ACE;
  logic         miso, tmode;
  logic [127:0] cfgq;
  logic [3:0]   cfgwr;

  spi_regbank uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .stat_in(stat), .cfg_q(cfgq), .cfg_wr(cfgwr), .test_mode(tmode)
  );

  always #(CLK_T/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] got;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          mcnt;
  logic [31:0] msh, mrd, mdata;
  logic [7:0]  mcmd;
  logic [31:0] mcfg [4];
  logic        mtest, mrise, mbit, mcs_now;
  logic [3:0]  mwr;
  logic        hs1, hs2, hs3, hc1, hc2, hm1, hm2;

  function automatic logic [31:0] mread(input logic [6:0] a);
    if (a < 7'd4) return mcfg[a[1:0]];
    if (a == 7'd4) return {31'b0, mtest};
    if (a == 7'd8) return stat[31:0];
    if (a == 7'd9) return stat[63:32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; msh = 0; mrd = 0; mcmd = 0; mtest = 0; mwr = 0; mcs_now = 1;
      for (int i = 0; i < 4; i++) mcfg[i] = 0;
      hs1 = 0; hs2 = 0; hs3 = 0; hc1 = 1; hc2 = 1; hm1 = 0; hm2 = 0;
    end else begin
      mwr = 0;
      mrise = hs2 && !hs3 && !hc2;
      mbit = hm2;
      if (hc2) mcnt = 0;
      else if (mrise && mcnt < 40) begin
        if (mcnt == 7) begin
          mcmd = {msh[6:0], mbit};
          if (mcmd[7]) mrd = mread(mcmd[6:0]);
        end
        if (mcnt == 39 && !mcmd[7]) begin
          mdata = {msh[30:0], mbit};
          if (mcmd[6:0] < 7'd4) begin
            mcfg[mcmd[1:0]] = mdata;
            mwr[mcmd[1:0]] = 1'b1;
          end else if (mcmd[6:0] == 7'd4) mtest = mdata[0];
        end
        msh = {msh[30:0], mbit};
        mcnt++;
      end
      mcs_now = hc1;
      hs3 = hs2; hs2 = hs1; hs1 = sck;
      hc2 = hc1; hc1 = cs_n;
      hm2 = hm1; hm1 = mosi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 cfg_q", cfgq, {mcfg[3], mcfg[2], mcfg[1], mcfg[0]});
      check("R2 cfg_wr", cfgwr, mwr);
      check("R4 test_mode", tmode, mtest);
      if (mcs_now) check("R9 miso idle", miso, 0);
      else if (mcmd[7] && mcnt >= 8) check("R3 miso bit", miso, (mcnt == 40) ? 1'b0 : mrd[39-mcnt]);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [31:0] d, input int nbits,
                      input int chg_at, input logic [63:0] chg_val, output logic [31:0] rd);
    logic [47:0] fr;
    fr = {c, d, 8'hA7};
    rd = 0;
    @(negedge clk);
    cs_n = 0;
    wait_cyc(HALF);
    for (int b = 0; b < nbits; b++) begin
      mosi = fr[47-b];
      if (b == chg_at) stat = chg_val;
      wait_cyc(HALF);
      if (b >= 8 && b < 40) rd[39-b] = miso;
      sck = 1;
      wait_cyc(HALF);
      sck = 0;
    end
    wait_cyc(HALF);
    cs_n = 1;
    mosi = 0;
    wait_cyc(8);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    xfer({1'b0, a}, d, 40, -1, 64'h0, dummy);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    xfer({1'b1, a}, 32'h0, 40, -1, 64'h0, v);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(1);
    check("R1 cfg_q reset", cfgq, 0);
    check("R1 test_mode reset", tmode, 0);
    check("R1 miso reset", miso, 0);
    check("R1 cfg_wr reset", cfgwr, 0);

    wr(7'd0, 32'hA5A5_1234); rd(7'd0, got); check("R2 R3 cfg0 readback", got, 32'hA5A5_1234);
    wr(7'd3, 32'hFFFF_0001); rd(7'd3, got); check("R2 R3 cfg3 readback", got, 32'hFFFF_0001);
    check("R2 cfg_q port", cfgq[127:96], 32'hFFFF_0001);

    wr(7'd4, 32'hFFFF_FFFF); rd(7'd4, got); check("R4 test read one", got, 32'h1);
    check("R4 test port", tmode, 1'b1);
    wr(7'd4, 32'hFFFF_FFFE); rd(7'd4, got); check("R4 test read zero", got, 32'h0);

    rd(7'd8, got); check("R5 stat0", got, 32'h0246_8ACE);
    rd(7'd9, got); check("R5 stat1", got, 32'h89AB_CDEF);
    wr(7'd8, 32'h5555_5555); rd(7'd8, got); check("R5 stat write ignored", got, 32'h0246_8ACE);

    rd(7'd5, got); check("R6 read gap", got, 0);
    rd(7'h7F, got); check("R6 read top", got, 0);
    wr(7'h40, 32'h1357_9BDF); wr(7'h7F, 32'h2468_ACE0);
    check("R6 cfg untouched", cfgq, {32'hFFFF_0001, 32'h0, 32'h0, 32'hA5A5_1234});

    wr(7'd1, 32'h1111_1111);
    xfer(8'h01, 32'hDEAD_BEEF, 30, -1, 64'h0, got);
    xfer(8'h01, 32'hDEAD_BEEF, 39, -1, 64'h0, got);
    rd(7'd1, got); check("R7 aborted write dropped", got, 32'h1111_1111);
    wr(7'd1, 32'h2222_2222); rd(7'd1, got); check("R7 next write ok", got, 32'h2222_2222);

    xfer(8'h89, 32'h0, 40, 20, 64'h0, got); check("R8 snapshot", got, 32'h89AB_CDEF);
    rd(7'd9, got); check("R5 live status", got, 32'h0);

    wr(7'd2, 32'hFFFF_FFFF);
    xfer(8'h82, 32'h0, 16, -1, 64'h0, got);
    check("R9 miso after abort", miso, 0);

    xfer(8'h02, 32'h3C3C_0F0F, 48, -1, 64'h0, got);
    rd(7'd2, got); check("R10 extra clocks ignored", got, 32'h3C3C_0F0F);

    wait_cyc(10);
    finish_run();
  end
endmodule